// File: doc/BRIEF.md
# Interrupt Gather and Status Register

This block is one 32-bit status and control word. Four interrupt sources feed it: two general-purpose input pins, a power-down request and an interrupt from a parallel port. It merges them onto a single active-low level interrupt line. Software reads the word to see the live state of each source. It writes the word to enable or mask each source's path to the interrupt line.

The pin inputs are asynchronous to `clk_i`. Each pin passes through a two-stage synchronizer. A 2-bit polarity field per pin, taken from a neighbouring control register, then shapes the pin into an internal state. That internal state is both the status bit and the pin's interrupt source.

The power-down request sets a sticky flag whether or not its enable is on. Any read of the word clears the flag, unless a new request arrives in the same cycle as the read. Read data is a combinational view of the word. A read only clears the flag at the clock edge.

Top module: `gis_top`

## Requirements
- R1: Bits 1:0, 17:4 and 31:24 always read as 0, and writing ones to them has no effect.
- R2: Bit 2 shows the internal state of pin 0 and bit 3 that of pin 1. The polarity setting gives pin 0 field bits 1:0 and pin 1 field bits 3:2. Field value 00 passes the synchronized pin as-is, 01 inverts it, and 10 or 11 hold the internal state at 0.
- R3: Bits 18 (pin 0 enable), 19 (pin 1 enable), 21 (power-down enable) and 23 (parallel-port enable) take the write data on a clock edge with `wr_en_i` high. Without `wr_en_i` they hold their value.
- R4: Bit 20 is set from the cycle after `pd_req_i` is high, whatever the value of bit 21.
- R5: A clock edge with `rd_en_i` high and `pd_req_i` low clears bit 20 from the next cycle. The data read in the read cycle still shows bit 20 set.
- R6: If `pd_req_i` and `rd_en_i` are high at the same edge, bit 20 stays set.
- R7: Bit 22 follows `lpt_irq_i` in the same cycle.
- R8: `irq_no` is 0 exactly when at least one of these pairs is both 1: bits 2 and 18, bits 3 and 19, bits 20 and 21, or bits 22 and 23.
- R9: After reset, or while reset is held low, the four enables and bit 20 are 0 and `irq_no` is 1.
- R10: A pin change reaches bit 2 or 3 on the second rising edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 2 | Asynchronous general-purpose pins, bit k is pin k |
| pin_pol_i | input | 4 | Polarity fields, bits 1:0 for pin 0 and bits 3:2 for pin 1 |
| pd_req_i | input | 1 | Power-down request, synchronous |
| lpt_irq_i | input | 1 | Parallel-port interrupt level |
| wr_en_i | input | 1 | Write strobe for this word |
| rd_en_i | input | 1 | Read strobe for this word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| irq_no | output | 1 | Merged interrupt, active low |

## Verification
A vector table sweeps each source alone with its enable on and off. Pins are applied under both the pass-through and the inverted polarity, to tell a live source gated by its enable from one that is merely present. Mixed vectors set several enables with only one active source, or with active sources whose enables are off, to show that the merge is a sum of gated pairs and not an OR of raw states. Directed sequences then separate the flag's set, clear, and same-edge set-during-read cases, the held-inactive polarity, the synchronizer's exact latency, writes to read-only bits, and a reset in mid-run.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned NPINS        = 2;
  localparam int unsigned PIN_STAT_LSB = 2;
  localparam int unsigned PIN_EN_LSB   = 18;
  localparam int unsigned PD_FLAG_BIT  = 20;
  localparam int unsigned PD_EN_BIT    = 21;
  localparam int unsigned LPT_STAT_BIT = 22;
  localparam int unsigned LPT_EN_BIT   = 23;
  localparam int unsigned NSRC         = NPINS + 2;
  localparam logic [REG_W-1:0] WR_MASK = (REG_W'(1) << PIN_EN_LSB) | (REG_W'(1) << (PIN_EN_LSB + 1))
                                       | (REG_W'(1) << PD_EN_BIT) | (REG_W'(1) << LPT_EN_BIT);
  localparam logic [REG_W-1:0] USED_MASK = WR_MASK | (REG_W'(1) << PIN_STAT_LSB)
                                         | (REG_W'(1) << (PIN_STAT_LSB + 1))
                                         | (REG_W'(1) << PD_FLAG_BIT) | (REG_W'(1) << LPT_STAT_BIT);
  localparam logic [REG_W-1:0] RSV_MASK = ~USED_MASK;

  typedef struct packed {
    logic lpt;
    logic pd;
    logic [NPINS-1:0] pin;
  } src_vec_t;
endpackage

// File: rtl/gis_pin_sync.sv
module gis_pin_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[k]};
    end
    assign sync_o[k] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gis_pd_flag.sv
module gis_pd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over a clearing read so a request is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/gis_irq_merge.sv
module gis_irq_merge #(
  parameter int unsigned NSRC = 4
) (
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_i,
  output logic            irq_no
);
  assign irq_no = ~|(src_i & en_i);
endmodule

// File: rtl/gis_top.sv
module gis_top
  import gis_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NPINS-1:0]     pin_i,
  input  logic [2*NPINS-1:0]   pin_pol_i,
  input  logic                 pd_req_i,
  input  logic                 lpt_irq_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 irq_no
);
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] pin_int;
  logic             pd_flag;
  src_vec_t         src;
  src_vec_t         en_q;
  logic             unused_wdata;

  gis_pin_sync #(.WIDTH(NPINS), .STAGES(2)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  // field 00: as-is, 01: inverted, 1x: held inactive
  for (genvar k = 0; k < NPINS; k++) begin : g_pol
    assign pin_int[k] = ~pin_pol_i[2*k+1] & (pin_sync[k] ^ pin_pol_i[2*k]);
  end

  gis_pd_flag i_pd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pd_req_i),
    .clr_i  (rd_en_i),
    .flag_o (pd_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (wr_en_i) begin
      en_q.pin <= wdata_i[PIN_EN_LSB +: NPINS];
      en_q.pd  <= wdata_i[PD_EN_BIT];
      en_q.lpt <= wdata_i[LPT_EN_BIT];
    end
  end

  assign unused_wdata = ^(wdata_i & ~WR_MASK);

  assign src.pin = pin_int;
  assign src.pd  = pd_flag;
  assign src.lpt = lpt_irq_i;

  gis_irq_merge #(.NSRC(NSRC)) i_merge (
    .src_i  (src),
    .en_i   (en_q),
    .irq_no (irq_no)
  );

  always_comb begin
    rdata_o = '0;
    rdata_o[PIN_STAT_LSB +: NPINS] = pin_int;
    rdata_o[PIN_EN_LSB +: NPINS]   = en_q.pin;
    rdata_o[PD_FLAG_BIT]           = pd_flag;
    rdata_o[PD_EN_BIT]             = en_q.pd;
    rdata_o[LPT_STAT_BIT]          = lpt_irq_i;
    rdata_o[LPT_EN_BIT]            = en_q.lpt;
  end
endmodule

// File: rtl/gis_chk.sv
module gis_chk
  import gis_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pd_req_i,
  input logic             rd_en_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             irq_no
);
  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & RSV_MASK) == '0);

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rdata_o & WR_MASK) == ($past(wdata_i) & WR_MASK));

  a_r3_no_write_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (rdata_o & WR_MASK) == ($past(rdata_o) & WR_MASK));

  a_r4_pd_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_req_i |=> rdata_o[PD_FLAG_BIT]);

  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !pd_req_i) |=> !rdata_o[PD_FLAG_BIT]);

  a_r8_pd_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[PD_FLAG_BIT] && rdata_o[PD_EN_BIT]) |-> !irq_no);

  a_r8_masked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o & WR_MASK) == '0) |-> irq_no);
endmodule

bind gis_top gis_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pd_req_i (pd_req_i),
  .rd_en_i  (rd_en_i),
  .wr_en_i  (wr_en_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_no   (irq_no)
);

// File: tb/test_gis_top.sv
module test_gis_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;
  // {en lpt,pd,p1,p0}[9:6] {pin1,pin0}[5:4] {inv1,inv0}[3:2] lpt[1] exp_irq_no[0]
  localparam logic [9:0] VEC [NVEC] = '{
    {4'b0000, 2'b11, 2'b00, 1'b1, 1'b1},
    {4'b0001, 2'b01, 2'b00, 1'b0, 1'b0},
    {4'b0001, 2'b01, 2'b01, 1'b0, 1'b1},
    {4'b0010, 2'b00, 2'b10, 1'b0, 1'b0},
    {4'b1000, 2'b00, 2'b00, 1'b0, 1'b1},
    {4'b1000, 2'b00, 2'b00, 1'b1, 1'b0},
    {4'b0111, 2'b00, 2'b00, 1'b1, 1'b1},
    {4'b1111, 2'b10, 2'b00, 1'b0, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  pin_i = '0;
  logic [3:0]  pin_pol_i = '0;
  logic        pd_req_i = 1'b0;
  logic        lpt_irq_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_no;
  int          n_run = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gis_top i_gis_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .pin_pol_i(pin_pol_i),
    .pd_req_i(pd_req_i), .lpt_irq_i(lpt_irq_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no)
  );

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [3:0] en, input logic [1:0] st,
                                       input logic pd, input logic lpt);
    logic [31:0] w = '0;
    w[3:2] = st; w[19:18] = en[1:0]; w[20] = pd; w[21] = en[2];
    w[22] = lpt; w[23] = en[3];
    return w;
  endfunction

  function automatic logic [31:0] en_word(input logic [3:0] en);
    return word(en, 2'b00, 1'b0, 1'b0);
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R9 reset rdata", rdata_o, 32'h0);
    chk("R9 reset irq", {31'b0, irq_no}, 32'h1);
    rst_ni = 1'b1;
    tick();
    chk("R9 after release", rdata_o, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [9:0] t = VEC[v];
      pin_i = t[5:4];
      pin_pol_i = {1'b0, t[3], 1'b0, t[2]};
      lpt_irq_i = t[1];
      wdata_i = en_word(t[9:6]);
      wr_en_i = 1'b1;
      tick();
      wr_en_i = 1'b0;
      tick();
      chk("R2 R3 R7 table word", rdata_o, word(t[9:6], t[5:4] ^ t[3:2], 1'b0, t[1]));
      chk("R8 table irq", {31'b0, irq_no}, {31'b0, t[0]});
    end

    // sticky power-down flag
    wdata_i = '0; wr_en_i = 1'b1; pin_i = '0; pin_pol_i = '0; lpt_irq_i = 1'b0;
    tick(); wr_en_i = 1'b0; tick();
    pd_req_i = 1'b1; tick(); pd_req_i = 1'b0;
    chk("R4 flag sets with enable off", rdata_o, word(4'b0000, 2'b00, 1'b1, 1'b0));
    chk("R8 flag masked", {31'b0, irq_no}, 32'h1);
    wdata_i = en_word(4'b0100); wr_en_i = 1'b1; tick(); wr_en_i = 1'b0;
    chk("R8 flag enabled", {31'b0, irq_no}, 32'h0);
    rd_en_i = 1'b1;
    chk("R5 read cycle shows flag", {31'b0, rdata_o[20]}, 32'h1);
    tick(); rd_en_i = 1'b0;
    chk("R5 flag cleared", {31'b0, rdata_o[20]}, 32'h0);
    chk("R5 irq released", {31'b0, irq_no}, 32'h1);
    pd_req_i = 1'b1; tick();
    rd_en_i = 1'b1; tick();
    pd_req_i = 1'b0; rd_en_i = 1'b0;
    chk("R6 request beats read", {31'b0, rdata_o[20]}, 32'h1);
    rd_en_i = 1'b1; tick(); rd_en_i = 1'b0;
    chk("R5 second read clears", {31'b0, rdata_o[20]}, 32'h0);

    // writes to read-only and reserved bits
    wdata_i = 32'hFFFF_FFFF; wr_en_i = 1'b1; tick(); wr_en_i = 1'b0;
    chk("R1 R3 all-ones write", rdata_o, 32'h00AC_0000);
    wdata_i = 32'h0; tick();
    chk("R3 no strobe holds", rdata_o, 32'h00AC_0000);

    // held-inactive polarity with pin 0 enabled
    pin_i = 2'b01; pin_pol_i = 4'b0010; tick(); tick();
    chk("R2 field 10 holds inactive", {31'b0, rdata_o[2]}, 32'h0);
    chk("R8 held pin no irq", {31'b0, irq_no}, 32'h1);
    pin_pol_i = 4'b0011; #1;
    chk("R2 field 11 holds inactive", {31'b0, rdata_o[2]}, 32'h0);
    pin_pol_i = 4'b0000; #1;
    chk("R2 field 00 passes", {31'b0, rdata_o[2]}, 32'h1);
    chk("R8 pin irq", {31'b0, irq_no}, 32'h0);

    // synchronizer latency
    pin_i = 2'b10; tick();
    chk("R10 one edge no change", {30'b0, rdata_o[3:2]}, 32'h1);
    tick();
    chk("R10 second edge lands", {30'b0, rdata_o[3:2]}, 32'h2);

    lpt_irq_i = 1'b1; #1;
    chk("R7 lpt same cycle", {31'b0, rdata_o[22]}, 32'h1);

    // reset in mid-run
    rst_ni = 1'b0; #1;
    chk("R9 mid reset enables", rdata_o & 32'h00BC_0000, 32'h0);
    chk("R9 mid reset irq", {31'b0, irq_no}, 32'h1);
    tick(); rst_ni = 1'b1; tick();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule